// File: doc/BRIEF.md
# Flash Section Partition and Write Guard

This block sits between the bus that issues program-memory and EEPROM accesses and the non-volatile arrays. It splits the flash address space into three regions (boot, application code and application data) using two 8-bit configuration values that count in 256-byte pages. For every access it reports the region of the target address. It also works out the region the program counter is executing from, and from that decides whether the access may go ahead.

Writes follow a strict privilege order. Boot code may write the two application regions. Application code may write only application data. Code running from application data may write nothing. Nothing may ever write the boot region.

Two sticky lock bits can only be set, and only a reset clears them. One write-protects the application code region. The other blocks reads and instruction fetches from the boot region. A refused access leaves the memory untouched and raises a violation pulse. All verdicts are registered: the region code, the permit flags and the violation flag for a request presented in one cycle appear after the next rising clock edge.

Top module: `flash_part_guard`

## Requirements
- R1: With boot_end_i nonzero, a flash address whose page (address bits above bit 7) is below boot_end_i is reported as region 2'b00 (boot), one cycle after the request.
- R2: A flash address whose page is at or above boot_end_i and below code_end_i is reported as region 2'b01 (application code).
- R3: A flash address at or above both limits is reported as region 2'b10 (application data). When code_end_i is not above boot_end_i there is no code region, and data starts right at the end of boot.
- R4: When boot_end_i is 0, every flash address is reported as region 2'b00, whatever code_end_i holds.
- R5: An EEPROM access (acc_eeprom_i=1) is reported as region 2'b11.
- R6: A flash write that targets the boot region is refused, whatever region the program counter is in.
- R7: With the program counter in boot, writes to application code, application data and EEPROM are permitted.
- R8: With the program counter in application code, writes to application data and EEPROM are permitted, and writes to application code are refused.
- R9: With the program counter in application data, every write to flash or EEPROM is refused.
- R10: After a pulse on lock_code_set_i, code_wp_o stays high until reset, and flash writes to application code are refused even from boot. Writes to application data are unaffected.
- R11: After a pulse on lock_boot_set_i, boot_lock_o stays high until reset, and reads or fetches of the boot region are refused. Reads of the other regions and of EEPROM remain permitted.
- R12: For each cycle in which a request is presented, exactly one of wr_permit_o, rd_permit_o or violation_o is high in the following cycle. In a cycle with no request, all three are low and the region output is 2'b00.
- R13: Reset (rst_n low at a clock edge) clears both lock bits and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_end_i | input | 8 | End of boot region, in 256-byte pages |
| code_end_i | input | 8 | End of application code region, in 256-byte pages |
| pc_addr_i | input | 16 | Byte address of the executing instruction |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read or fetch |
| acc_eeprom_i | input | 1 | Access targets EEPROM rather than flash |
| acc_addr_i | input | 16 | Target byte address |
| lock_code_set_i | input | 1 | Sets the application-code write-protect lock |
| lock_boot_set_i | input | 1 | Sets the boot lock |
| acc_region_o | output | 2 | Region code of the last request |
| wr_permit_o | output | 1 | Last request was a permitted write |
| rd_permit_o | output | 1 | Last request was a permitted read or fetch |
| violation_o | output | 1 | Last request was refused |
| code_wp_o | output | 1 | Application-code write-protect lock state |
| boot_lock_o | output | 1 | Boot lock state |

## Verification
The bench probes the last and first byte of each region, since an off-by-one page compare would move byte 1023 or 1024 into the wrong region. It also covers a code limit at or below the boot limit, which a design that ignored that ordering would decode as a phantom code region, and a zero boot limit, which a design that forgot the special case would decode as data. Writes are tried from each program-counter region to each target, including EEPROM from data code, so that a loosened privilege check would appear as a permit. The locks are set and then checked again several requests later and after a reset, which exposes a lock that is level-driven rather than sticky, or one that survives reset.

// File: rtl/fpg_pkg.sv
// Package: shared region encoding for the flash partition guard.
// Assumes the encoding is visible at the top ports, so the values are fixed.
package fpg_pkg;
    typedef enum logic [1:0] {
        REG_BOOT = 2'b00,
        REG_CODE = 2'b01,
        REG_DATA = 2'b10,
        REG_EEP  = 2'b11
    } region_e;
endpackage

// File: rtl/fpg_region_dec.sv
// Region decoder: maps a flash byte address to boot, code or data using
// two page-granular limits. Purely combinational.
// Assumes a page is 2**PAGE_SHIFT bytes and that the limits count pages.
module fpg_region_dec
    import fpg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CFG_W      = 8,
    parameter int PAGE_SHIFT = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  boot_end_i,
    input  logic [CFG_W-1:0]  code_end_i,
    output region_e           region_o
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int CMP_W  = (PAGE_W > CFG_W) ? PAGE_W : CFG_W;

    logic [CMP_W-1:0] page_x, boot_x, code_x;

    assign page_x = CMP_W'(addr_i[ADDR_W-1:PAGE_SHIFT]);
    assign boot_x = CMP_W'(boot_end_i);
    assign code_x = CMP_W'(code_end_i);

    // Compare the page number against both limits; zero boot limit means all boot.
    always_comb begin
        if (boot_x == '0 || page_x < boot_x) begin
            region_o = REG_BOOT;
        end else if (code_x > boot_x && page_x < code_x) begin
            region_o = REG_CODE;
        end else begin
            region_o = REG_DATA;
        end
    end
endmodule

// File: rtl/fpg_lock_regs.sv
// Lock registers: two set-only bits that only a reset clears.
// Assumes set requests are single-cycle or level; either way the bit sticks.
module fpg_lock_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic set_code_i,
    input  logic set_boot_i,
    output logic code_wp_o,
    output logic boot_lock_o
);
    // Accumulate set requests; reset is the only way back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_wp_o   <= 1'b0;
            boot_lock_o <= 1'b0;
        end else begin
            code_wp_o   <= code_wp_o | set_code_i;
            boot_lock_o <= boot_lock_o | set_boot_i;
        end
    end

    assert_code_wp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        code_wp_o |=> code_wp_o);
    assert_boot_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_lock_o |=> boot_lock_o);
    assert_code_wp_only_by_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_wp_o && !set_code_i) |=> !code_wp_o);
endmodule

// File: rtl/fpg_permit.sv
// Permission logic: decides whether the current request may proceed from the
// target region, the executing region and the lock state. Combinational.
// Assumes EEPROM is never affected by the flash locks.
module fpg_permit
    import fpg_pkg::*;
(
    input  logic    valid_i,
    input  logic    write_i,
    input  logic    eeprom_i,
    input  region_e tgt_i,
    input  region_e pc_i,
    input  logic    code_wp_i,
    input  logic    boot_lock_i,
    output logic    wr_ok_o,
    output logic    rd_ok_o,
    output logic    refuse_o
);
    logic write_allowed;
    logic read_allowed;

    // Write privilege: boot > code > data, boot region never writable.
    always_comb begin
        write_allowed = 1'b0;
        if (eeprom_i) begin
            write_allowed = (pc_i != REG_DATA);
        end else begin
            unique case (tgt_i)
                REG_CODE: write_allowed = (pc_i == REG_BOOT) && !code_wp_i;
                REG_DATA: write_allowed = (pc_i == REG_BOOT) || (pc_i == REG_CODE);
                default:  write_allowed = 1'b0;
            endcase
        end
    end

    // Read and fetch gating: only boot reads under boot lock are refused.
    always_comb begin
        read_allowed = !(!eeprom_i && tgt_i == REG_BOOT && boot_lock_i);
    end

    // Split the verdict into the three mutually exclusive outcomes.
    always_comb begin
        wr_ok_o  = valid_i &&  write_i && write_allowed;
        rd_ok_o  = valid_i && !write_i && read_allowed;
        refuse_o = valid_i && (write_i ? !write_allowed : !read_allowed);
    end
endmodule

// File: rtl/flash_part_guard.sv
// Top: flash section partition and write guard. Decodes the target and the
// executing region, holds the sticky locks and registers one verdict per request.
// Assumes the PC and access addresses are byte addresses in the same flash space.
module flash_part_guard
    import fpg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CFG_W      = 8,
    parameter int PAGE_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  boot_end_i,
    input  logic [CFG_W-1:0]  code_end_i,
    input  logic [ADDR_W-1:0] pc_addr_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic              acc_eeprom_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              lock_code_set_i,
    input  logic              lock_boot_set_i,
    output logic [1:0]        acc_region_o,
    output logic              wr_permit_o,
    output logic              rd_permit_o,
    output logic              violation_o,
    output logic              code_wp_o,
    output logic              boot_lock_o
);
    localparam int N_DEC = 2;

    logic [ADDR_W-1:0] dec_addr [N_DEC];
    region_e           dec_reg  [N_DEC];
    region_e           tgt_region, pc_region, rep_region;
    logic              wr_ok, rd_ok, refuse;

    assign dec_addr[0] = acc_addr_i;
    assign dec_addr[1] = pc_addr_i;

    // One decoder for the target address and one for the program counter.
    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        fpg_region_dec #(
            .ADDR_W(ADDR_W), .CFG_W(CFG_W), .PAGE_SHIFT(PAGE_SHIFT)
        ) dec_i (
            .addr_i(dec_addr[g]), .boot_end_i(boot_end_i),
            .code_end_i(code_end_i), .region_o(dec_reg[g])
        );
    end

    assign tgt_region = dec_reg[0];
    assign pc_region  = dec_reg[1];

    fpg_lock_regs lock_i (
        .clk(clk), .rst_n(rst_n),
        .set_code_i(lock_code_set_i), .set_boot_i(lock_boot_set_i),
        .code_wp_o(code_wp_o), .boot_lock_o(boot_lock_o)
    );

    fpg_permit permit_i (
        .valid_i(acc_valid_i), .write_i(acc_write_i), .eeprom_i(acc_eeprom_i),
        .tgt_i(tgt_region), .pc_i(pc_region),
        .code_wp_i(code_wp_o), .boot_lock_i(boot_lock_o),
        .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .refuse_o(refuse)
    );

    // Region to report: EEPROM overrides, idle reports boot encoding.
    always_comb begin
        if (!acc_valid_i)      rep_region = REG_BOOT;
        else if (acc_eeprom_i) rep_region = REG_EEP;
        else                   rep_region = tgt_region;
    end

    // Register the verdict so every output changes one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_region_o <= 2'b00;
            wr_permit_o  <= 1'b0;
            rd_permit_o  <= 1'b0;
            violation_o  <= 1'b0;
        end else begin
            acc_region_o <= rep_region;
            wr_permit_o  <= wr_ok;
            rd_permit_o  <= rd_ok;
            violation_o  <= refuse;
        end
    end

    assert_boot_write_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && !acc_eeprom_i && tgt_region == REG_BOOT)
        |=> (violation_o && !wr_permit_o));
    assert_data_pc_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && pc_region == REG_DATA) |=> violation_o);
    assert_boot_lock_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_write_i && !acc_eeprom_i && boot_lock_o
         && tgt_region == REG_BOOT) |=> (violation_o && !rd_permit_o));
    assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> $countones({wr_permit_o, rd_permit_o, violation_o}) == 1);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !(wr_permit_o || rd_permit_o || violation_o));
endmodule

// File: tb/flash_part_guard_tb_top.sv
// Directed bench for flash_part_guard: one task per scenario.
module flash_part_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  boot_end, code_end;
    logic [15:0] pc_addr, acc_addr;
    logic        acc_valid, acc_write, acc_eeprom;
    logic        lock_code_set, lock_boot_set;
    logic [1:0]  acc_region;
    logic        wr_permit, rd_permit, violation, code_wp, boot_lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] PC_BOOT = 16'h0100;
    localparam logic [15:0] PC_CODE = 16'h0500;
    localparam logic [15:0] PC_DATA = 16'h1000;

    always #5 clk = ~clk;

    flash_part_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .boot_end_i(boot_end), .code_end_i(code_end),
        .pc_addr_i(pc_addr), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_eeprom_i(acc_eeprom), .acc_addr_i(acc_addr),
        .lock_code_set_i(lock_code_set), .lock_boot_set_i(lock_boot_set),
        .acc_region_o(acc_region), .wr_permit_o(wr_permit), .rd_permit_o(rd_permit),
        .violation_o(violation), .code_wp_o(code_wp), .boot_lock_o(boot_lock)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request at a negedge; verdict sampled at the following negedge.
    task automatic access(input string tag, input logic [15:0] pc, input logic [15:0] addr,
                          input logic wr, input logic ee, input logic [1:0] exp_reg,
                          input logic exp_wr, input logic exp_rd, input logic exp_vio);
        pc_addr = pc; acc_addr = addr; acc_write = wr; acc_eeprom = ee; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check(tag, {6'b0, acc_region}, {6'b0, exp_reg});
        check(tag, {5'b0, wr_permit, rd_permit, violation}, {5'b0, exp_wr, exp_rd, exp_vio});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R13 reset outputs", {2'b0, acc_region, wr_permit, rd_permit, violation, code_wp},
              8'h00);
        check("R13 reset boot lock", {7'b0, boot_lock}, 8'h00);
    endtask

    task automatic t_decode();
        boot_end = 8'd4; code_end = 8'd8;
        access("R1 first boot byte", PC_BOOT, 16'h0000, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        access("R1 last boot byte",  PC_BOOT, 16'h03FF, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        access("R2 first code byte", PC_BOOT, 16'h0400, 1'b0, 1'b0, 2'b01, 0, 1, 0);
        access("R2 last code byte",  PC_BOOT, 16'h07FF, 1'b0, 1'b0, 2'b01, 0, 1, 0);
        access("R3 first data byte", PC_BOOT, 16'h0800, 1'b0, 1'b0, 2'b10, 0, 1, 0);
        access("R3 top data byte",   PC_BOOT, 16'hFFFF, 1'b0, 1'b0, 2'b10, 0, 1, 0);
        access("R5 eeprom region",   PC_BOOT, 16'h0010, 1'b0, 1'b1, 2'b11, 0, 1, 0);
        // No code region when the code limit does not exceed the boot limit.
        code_end = 8'd0;
        access("R3 no code region",  PC_BOOT, 16'h0400, 1'b0, 1'b0, 2'b10, 0, 1, 0);
        code_end = 8'd3;
        access("R3 code below boot", PC_BOOT, 16'h0400, 1'b0, 1'b0, 2'b10, 0, 1, 0);
        boot_end = 8'd0; code_end = 8'd8;
        access("R4 zero boot low",   PC_BOOT, 16'h0500, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        access("R4 zero boot high",  PC_BOOT, 16'hF000, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        boot_end = 8'd4; code_end = 8'd8;
    endtask

    task automatic t_write_privilege();
        access("R6 boot->boot",    PC_BOOT, 16'h0200, 1'b1, 1'b0, 2'b00, 0, 0, 1);
        access("R6 code->boot",    PC_CODE, 16'h0200, 1'b1, 1'b0, 2'b00, 0, 0, 1);
        access("R7 boot->code",    PC_BOOT, 16'h0600, 1'b1, 1'b0, 2'b01, 1, 0, 0);
        access("R7 boot->data",    PC_BOOT, 16'h0900, 1'b1, 1'b0, 2'b10, 1, 0, 0);
        access("R7 boot->eeprom",  PC_BOOT, 16'h0020, 1'b1, 1'b1, 2'b11, 1, 0, 0);
        access("R8 code->code",    PC_CODE, 16'h0600, 1'b1, 1'b0, 2'b01, 0, 0, 1);
        access("R8 code->data",    PC_CODE, 16'h0900, 1'b1, 1'b0, 2'b10, 1, 0, 0);
        access("R8 code->eeprom",  PC_CODE, 16'h0020, 1'b1, 1'b1, 2'b11, 1, 0, 0);
        access("R9 data->data",    PC_DATA, 16'h0900, 1'b1, 1'b0, 2'b10, 0, 0, 1);
        access("R9 data->code",    PC_DATA, 16'h0600, 1'b1, 1'b0, 2'b01, 0, 0, 1);
        access("R9 data->eeprom",  PC_DATA, 16'h0020, 1'b1, 1'b1, 2'b11, 0, 0, 1);
        // Idle cycle after a refusal: pulse must have dropped.
        @(negedge clk);
        check("R12 idle after violation", {4'b0, acc_region, violation, wr_permit | rd_permit},
              8'h00);
    endtask

    task automatic t_locks();
        @(negedge clk);
        lock_code_set = 1'b1;
        @(negedge clk);
        lock_code_set = 1'b0;
        check("R10 code lock set", {7'b0, code_wp}, 8'h01);
        access("R10 boot->code locked", PC_BOOT, 16'h0600, 1'b1, 1'b0, 2'b01, 0, 0, 1);
        access("R10 boot->data ok",     PC_BOOT, 16'h0900, 1'b1, 1'b0, 2'b10, 1, 0, 0);
        access("R11 boot read no lock", PC_CODE, 16'h0100, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        lock_boot_set = 1'b1;
        @(negedge clk);
        lock_boot_set = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 code lock sticky", {6'b0, code_wp, boot_lock}, 8'h03);
        access("R11 boot read locked",  PC_CODE, 16'h0100, 1'b0, 1'b0, 2'b00, 0, 0, 1);
        access("R11 code read ok",      PC_CODE, 16'h0600, 1'b0, 1'b0, 2'b01, 0, 1, 0);
        access("R11 eeprom read ok",    PC_CODE, 16'h0030, 1'b0, 1'b1, 2'b11, 0, 1, 0);
        do_reset();
        check("R13 locks cleared", {6'b0, code_wp, boot_lock}, 8'h00);
        access("R13 boot read after reset", PC_CODE, 16'h0100, 1'b0, 1'b0, 2'b00, 0, 1, 0);
        access("R13 code write after reset", PC_BOOT, 16'h0600, 1'b1, 1'b0, 2'b01, 1, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; boot_end = 8'd4; code_end = 8'd8;
        pc_addr = '0; acc_addr = '0; acc_valid = 1'b0; acc_write = 1'b0; acc_eeprom = 1'b0;
        lock_code_set = 1'b0; lock_boot_set = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_write_privilege();
        t_locks();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule